// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This unit rearranges bytes under the control of a stored permutation pattern. It holds a 32-bit pattern register and carries out two operations. The mask-set operation adds two 64-bit integer operands. It returns the sum and writes the low half of that sum into the pattern register. The shuffle operation builds a 64-bit word. Each of its eight bytes is taken from any of the sixteen bytes of two 64-bit source operands, and the choice for each byte comes from one nibble of the stored pattern.

The register written by one operation steers a later one, so a result depends on the order in which operations arrive. A caller sets the pattern once with a mask-set, then issues any number of shuffles against it. Every accepted operation produces its result one clock later, and the pattern register is visible on an output at all times.

Top module: `byte_permute_unit`

## Requirements
- R1: A synchronous active-high reset clears the pattern register to zero, drives res_valid low and clears res_data to zero.
- R2: A mask-set is an operation with op_valid high and op_sel equal to 9'h019. In the next cycle res_valid is high and res_data equals opnd_a + opnd_b modulo 2^64, with no carry out.
- R3: After a mask-set, mask_q holds bits 31:0 of that sum from the next cycle on.
- R4: A shuffle is an operation with op_valid high and op_sel equal to 9'h04C. In the next cycle res_valid is high. Result bits 8i+7:8i come from the index k held in mask_q bits 4i+3:4i. For k from 0 to 7 that byte is byte k of opnd_a, and for k from 8 to 15 it is byte k-8 of opnd_b. Byte 0 is bits 7:0.
- R5: A shuffle leaves mask_q unchanged.
- R6: A shuffle in the cycle right after a mask-set uses the pattern written by that mask-set.
- R7: In a cycle where op_valid is low, or where op_sel matches neither code, the operation is ignored. In the next cycle res_valid is low, and res_data and mask_q keep their values.
- R8: After reset and before any mask-set, a shuffle fills all eight result bytes with byte 0 of opnd_a.
- R9: res_valid is high in exactly those cycles that follow a cycle with a recognised operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 9 | Operation select code |
| opnd_a | input | 64 | First operand / first shuffle source |
| opnd_b | input | 64 | Second operand / second shuffle source |
| res_valid | output | 1 | res_data carries a fresh result |
| res_data | output | 64 | Sum or shuffled word |
| mask_q | output | 32 | Current byte-pattern register |

## Verification
The bench goes after ordering. It issues a shuffle in the cycle directly after a mask-set, and a design that read the pattern too early would return bytes picked by the stale pattern. It also drives index nibbles 7, 8 and 15, so a design that split the two sources at the wrong index, or numbered bytes from the wrong end, would return a byte from the wrong operand. Sums that carry across bit 31 and wrap past bit 63 would show a truncated or carry-leaking adder. Select codes one bit away from a valid code, and cycles with op_valid low, would show a decoder that lets such a cycle write the pattern or raise res_valid.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    localparam int WORD_W = 64;
    localparam int MASK_W = 32;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 9;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int POOL   = 2 * LANES;
    localparam int IDX_W  = $clog2(POOL);

    localparam logic [SEL_W-1:0] SEL_MSET = 9'h019;
    localparam logic [SEL_W-1:0] SEL_SHUF = 9'h04C;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_MSET = 2'd1,
        OP_SHUF = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } result_t;

    function automatic op_kind_e decode_op(input logic vld, input logic [SEL_W-1:0] sel);
        op_kind_e k;
        k = OP_NONE;
        if (vld) begin
            if (sel == SEL_MSET)      k = OP_MSET;
            else if (sel == SEL_SHUF) k = OP_SHUF;
        end
        return k;
    endfunction

endpackage

// File: rtl/bpu_adder.sv
module bpu_adder #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] sum_out
);
    // The carry out of the top bit is discarded: modulo 2^WIDTH.
    always_comb begin
        sum_out = a_in + b_in;
    end
endmodule

// File: rtl/bpu_mask_reg.sv
module bpu_mask_reg #(
    parameter int MW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [MW-1:0] load_val,
    output logic [MW-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (load) mask_q <= load_val;
    end
endmodule

// File: rtl/bpu_lane_pick.sv
module bpu_lane_pick #(
    parameter int BW    = 8,
    parameter int NLANE = 8,
    localparam int NPOOL = 2 * NLANE,
    localparam int IW    = $clog2(NPOOL)
) (
    input  logic [NLANE*BW-1:0] src_lo,
    input  logic [NLANE*BW-1:0] src_hi,
    input  logic [IW-1:0]       idx,
    output logic [BW-1:0]       byte_out
);
    logic [BW-1:0] pool [NPOOL];

    // Pool entries 0..NLANE-1 come from the first source, the rest from the second.
    for (genvar p = 0; p < NLANE; p++) begin : g_pool
        assign pool[p]         = src_lo[p*BW +: BW];
        assign pool[p + NLANE] = src_hi[p*BW +: BW];
    end

    always_comb begin
        byte_out = pool[idx];
    end
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
    import bpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [SEL_W-1:0]    op_sel,
    input  logic [WORD_W-1:0]   opnd_a,
    input  logic [WORD_W-1:0]   opnd_b,
    output logic                res_valid,
    output logic [WORD_W-1:0]   res_data,
    output logic [MASK_W-1:0]   mask_q
);
    op_kind_e          kind;
    logic [WORD_W-1:0] sum_w;
    logic [WORD_W-1:0] shuf_w;
    result_t           nxt;
    result_t           res_q;

    assign kind = decode_op(op_valid, op_sel);

    bpu_adder #(.WIDTH(WORD_W)) u_add (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .sum_out (sum_w)
    );

    // The pattern register is written at the same edge that registers the
    // mask-set result, so a shuffle in the next cycle already sees it.
    bpu_mask_reg #(.MW(MASK_W)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .load     (kind == OP_MSET),
        .load_val (sum_w[MASK_W-1:0]),
        .mask_q   (mask_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bpu_lane_pick #(.BW(BYTE_W), .NLANE(LANES)) u_pick (
            .src_lo   (opnd_a),
            .src_hi   (opnd_b),
            .idx      (mask_q[i*IDX_W +: IDX_W]),
            .byte_out (shuf_w[i*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        nxt.vld  = 1'b0;
        nxt.data = res_q.data;
        unique case (kind)
            OP_MSET: begin nxt.vld = 1'b1; nxt.data = sum_w;  end
            OP_SHUF: begin nxt.vld = 1'b1; nxt.data = shuf_w; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign res_valid = res_q.vld;
    assign res_data  = res_q.data;

    // ---------------- assertions ----------------
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        armed |-> (res_valid == $past(op_valid && (op_sel == SEL_MSET || op_sel == SEL_SHUF))));

    p_sum_result_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_valid && op_sel == SEL_MSET)) |-> (res_data == $past(opnd_a + opnd_b)));

    p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_valid && op_sel == SEL_MSET))
            |-> (mask_q == $past(opnd_a[MASK_W-1:0] + opnd_b[MASK_W-1:0])));

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(op_valid && op_sel == SEL_MSET)) |-> $stable(mask_q));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(op_valid)) |-> (!res_valid && $stable(res_data)));

endmodule

// File: tb/sim_byte_permute_unit.sv
module sim_byte_permute_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [8:0]  op_sel;
    logic [63:0] opnd_a, opnd_b;
    logic        res_valid;
    logic [63:0] res_data;
    logic [31:0] mask_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_mask;
    logic [63:0] m_data;

    always #10 clk = ~clk;

    byte_permute_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_valid(res_valid), .res_data(res_data), .mask_q(mask_q)
    );

    function automatic logic [63:0] ref_shuf(input logic [31:0] m, input logic [63:0] a,
                                             input logic [63:0] b);
        logic [63:0] r;
        logic [127:0] pool;
        pool = {b, a};
        for (int i = 0; i < 8; i++) begin
            int k;
            k = int'(m[4*i +: 4]);
            r[8*i +: 8] = pool[8*k +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge, after the result registered.
    task automatic issue(input logic v, input logic [8:0] s, input logic [63:0] a, input logic [63:0] b);
        op_valid = v; op_sel = s; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic mset(input logic [63:0] a, input logic [63:0] b, input string req);
        logic [63:0] s;
        s = a + b;
        issue(1'b1, 9'h019, a, b);
        m_mask = s[31:0]; m_data = s;
        check({req, " R2 valid"}, 64'(res_valid), 64'd1);
        check({req, " R2 sum"}, res_data, s);
        check({req, " R3 mask"}, 64'(mask_q), 64'(m_mask));
    endtask

    task automatic shuf(input logic [63:0] a, input logic [63:0] b, input string req);
        issue(1'b1, 9'h04C, a, b);
        m_data = ref_shuf(m_mask, a, b);
        check({req, " R4 valid"}, 64'(res_valid), 64'd1);
        check({req, " R4 data"}, res_data, m_data);
        check({req, " R5 mask kept"}, 64'(mask_q), 64'(m_mask));
    endtask

    task automatic noop(input logic v, input logic [8:0] s, input logic [63:0] a,
                        input logic [63:0] b, input string req);
        issue(v, s, a, b);
        check({req, " R7 no valid"}, 64'(res_valid), 64'd0);
        check({req, " R7 data held"}, res_data, m_data);
        check({req, " R7 mask held"}, 64'(mask_q), 64'(m_mask));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240611));
        rst = 1'b1; op_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        m_mask = '0; m_data = '0;
        repeat (3) @(negedge clk);
        check("R1 mask", 64'(mask_q), 64'd0);
        check("R1 valid", 64'(res_valid), 64'd0);
        check("R1 data", res_data, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle after reset", 64'(res_valid), 64'd0);

        // R8: zero pattern replicates byte 0 of the first source
        issue(1'b1, 9'h04C, 64'h1122334455667788, 64'hAABBCCDDEEFF0099);
        check("R8 replicate", res_data, 64'h8888888888888888);

        // R2 wrap and carry across bit 31
        mset(64'hFFFFFFFFFFFFFFFF, 64'h0000000000000002, "wrap");
        mset(64'h00000000FFFFFFFF, 64'h0000000000000001, "carry32");

        // R6 back-to-back: pattern picks boundary indices 7, 8, 15, 0
        mset(64'h0, 64'h00000000F870F870, "b2b set");
        shuf(64'h0706050403020100, 64'h0F0E0D0C0B0A0908, "R6 b2b");
        check("R6 expect", res_data, 64'h0F080700_0F080700);
        mset(64'h0, 64'h0000000089ABCDEF, "reverse set");
        shuf(64'h0706050403020100, 64'h0F0E0D0C0B0A0908, "R6 b2b2");
        check("R6 expect2", res_data, 64'h08090A0B0C0D0E0F);

        // R7 near-miss select codes and op_valid low
        noop(1'b1, 9'h018, 64'h5, 64'h6, "sel 018");
        noop(1'b1, 9'h04D, 64'h5, 64'h6, "sel 04D");
        noop(1'b0, 9'h019, 64'h5, 64'h6, "valid low mset");
        noop(1'b0, 9'h04C, 64'h5, 64'h6, "valid low shuf");

        for (int n = 0; n < 400; n++) begin
            logic [63:0] a, b;
            int c;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = int'($urandom % 10);
            if (c < 4)      mset(a, b, "rand R2");
            else if (c < 8) shuf(a, b, "rand R4");
            else if (c < 9) noop(1'b1, 9'($urandom), a, b, "rand R7") ;
            else            noop(1'b0, 9'h019, a, b, "rand R9");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule